// File: doc/BRIEF.md
# Maskable Interrupt Status Unit with Transfer Window Watch

This block gathers interrupt events into a pending store, exposes them through a clear-on-read status register and a mask register, and drives one active-low interrupt line to the processor. The processor uses a plain register bus with address, read strobe, write strobe and write data. Read data is combinational and valid in the cycle `bus_rd` is high. Each access completes in one cycle; there is no back-pressure and no wait state.

Besides the external sources, the unit watches a processor access window for synchronous transfers. A window-open event is raised when the window opens and at least one of the two transfer channels is enabled. An overflow event is raised if the processor did not touch either transfer data register before the window closed. The frame-timing logic and transfer data path are outside the block. Strobe inputs stand in for window open and close, and an access pulse stands in for a data register access.

Masked events are not lost: they wait in the pending store and become visible once unmasked. The frame event always shows in the status view but never drives the pin. A mask write made while the line is asserted forces it inactive briefly so the processor sees a fresh edge.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the mask register reads 0x00, the status register reads 0x00 and `irq_n` is 1.
- R2: Status bit layout is: bit 0 overflow, bit 1 window-open, bits 2..6 `ext_evt[0..4]`, bit 7 frame event. `irq_n` is 0 exactly when a visible status bit in 0..6 is set and no blanking pulse is running. A mask bit of 1 hides and blocks the matching bit.
- R3: An event whose mask bit is 1 is held pending. It appears in the status register, and drives `irq_n` low, in the cycle after that mask bit is written to 0.
- R4: The frame event (bit 7) is visible in the status register whatever the mask says, and it never drives `irq_n` low.
- R5: A mask write accepted while `irq_n` is logically asserted holds `irq_n` at 1 for exactly the two cycles after the write edge. The line is then re-evaluated with the new mask.
- R6: `win_open` sets status bit 1 only if `chan_en` is not 2'b00. With both channels disabled, the window neither opens nor sets any bit.
- R7: `win_close` on an open window sets status bit 0 if no `xfer_access` pulse was seen since the window opened, counting the closing cycle. Otherwise it sets nothing.
- R8: A read at offset 0 returns the visible status and clears exactly the bits it returned. Masked pending bits survive the read.
- R9: An event arriving in the same cycle as a clearing status read leaves its bit set after the read.
- R10: Offset 0 is read-only, and writes to it are ignored. Offset 1 is the read/write mask. Offsets 2 and 3 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe; offset 0 read clears shown bits |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_n | output | 1 | Active-low interrupt line |
| ext_evt | input | 5 | External event pulses (status bits 2..6) |
| frame_evt | input | 1 | Frame event pulse (status bit 7, mask-bypassing) |
| chan_en | input | 2 | Transfer channel A/B enables |
| win_open | input | 1 | Access window opens |
| win_close | input | 1 | Access window closes |
| xfer_access | input | 1 | Processor touched a transfer data register |

## Verification
The bench uses the default parameters: five external sources, which give an 8-bit register, and a two-cycle blanking pulse. With five sources, every source type sits in one byte, so a random mix of mask writes, clearing reads and event pulses can hit every bit position. That mix includes events in the same cycle as reads. The two-cycle blanking length lets mask writes overlap a running pulse. It also lets windows open, close and be accessed in every relative order within a few cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] OFS_STATUS = 2'd0;
  localparam logic [1:0] OFS_MASK   = 2'd1;
  localparam int BIT_OVF  = 0;
  localparam int BIT_WOPN = 1;
  localparam int BIT_EXT0 = 2;
endpackage

// File: rtl/irq_xfer_win.sv
module irq_xfer_win (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] chan_en,
  input  logic       win_open,
  input  logic       win_close,
  input  logic       xfer_access,
  output logic       wopen_evt,
  output logic       ovf_evt
);
  logic win_act, touched;
  logic open_ok;

  assign open_ok   = win_open && (chan_en != 2'b00);
  assign wopen_evt = open_ok;
  assign ovf_evt   = win_close && win_act && !(touched || xfer_access);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_act <= 1'b0;
      touched <= 1'b0;
    end else if (open_ok) begin
      win_act <= 1'b1;
      touched <= 1'b0;
    end else if (win_close) begin
      win_act <= 1'b0;
    end else if (win_act && xfer_access) begin
      touched <= 1'b1;
    end
  end

  AST_NO_OPEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && chan_en == 2'b00 && !win_act && !win_close) |=> !win_act) else $error("window opened with no channel"); // R6
  AST_ACCESS_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_access && win_act) |-> !ovf_evt) else $error("overflow despite access"); // R7
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int DW      = 8,
  parameter int BYP_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wdata,
  input  logic          stat_clr,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] vis,
  output logic          req
);
  logic [DW-1:0] pend;
  logic [DW-1:0] pin_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == BYP_BIT) begin : g_byp
      assign vis[i]     = pend[i];
      assign pin_sel[i] = 1'b0;
    end else begin : g_norm
      assign vis[i]     = pend[i] && !mask_q[i];
      assign pin_sel[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= (pend[i] && !(stat_clr && vis[i])) || evt[i];
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> pend[i]) else $error("event lost"); // R9
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && vis[i] && !evt[i]) |=> !pend[i]) else $error("read did not clear"); // R8
    AST_MASKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !vis[i]) |=> pend[i]) else $error("masked event dropped"); // R3
  end

  assign req = |(vis & pin_sel);

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata))) else $error("mask write lost"); // R10
endmodule

// File: rtl/irq_out_ctl.sv
module irq_out_ctl #(
  parameter int BLANK_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic mask_we,
  output logic irq_n
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  logic [CW-1:0] blank_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                blank_cnt <= '0;
    else if (mask_we && req)   blank_cnt <= CW'(BLANK_CYC);
    else if (blank_cnt != '0)  blank_cnt <= blank_cnt - 1'b1;
  end

  assign irq_n = !req || (blank_cnt != '0);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> irq_n) else $error("irq without request"); // R2
  if (BLANK_CYC >= 2) begin : g_chk
    AST_BLANK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && req) |=> irq_n) else $error("no blank cycle 1"); // R5
    AST_BLANK_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && req) |=> ##1 irq_n) else $error("no blank cycle 2"); // R5
  end
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit #(
  parameter int N_EXT     = 5,
  parameter int BLANK_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [N_EXT+2:0] bus_wdata,
  output logic [N_EXT+2:0] bus_rdata,
  output logic             irq_n,
  input  logic [N_EXT-1:0] ext_evt,
  input  logic             frame_evt,
  input  logic [1:0]       chan_en,
  input  logic             win_open,
  input  logic             win_close,
  input  logic             xfer_access
);
  import irq_pkg::*;
  localparam int DW      = N_EXT + 3;
  localparam int BYP_BIT = DW - 1;

  logic          wopen_evt, ovf_evt, req, stat_clr, mask_we;
  logic [DW-1:0] evt, mask_q, vis;

  assign stat_clr = bus_rd && (bus_addr == OFS_STATUS);
  assign mask_we  = bus_wr && (bus_addr == OFS_MASK);
  assign evt      = {frame_evt, ext_evt, wopen_evt, ovf_evt};

  irq_xfer_win u_win (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .win_open(win_open),
    .win_close(win_close), .xfer_access(xfer_access),
    .wopen_evt(wopen_evt), .ovf_evt(ovf_evt)
  );

  irq_pend_bank #(.DW(DW), .BYP_BIT(BYP_BIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt), .mask_we(mask_we),
    .mask_wdata(bus_wdata), .stat_clr(stat_clr),
    .mask_q(mask_q), .vis(vis), .req(req)
  );

  irq_out_ctl #(.BLANK_CYC(BLANK_CYC)) u_out (
    .clk(clk), .rst_n(rst_n), .req(req), .mask_we(mask_we), .irq_n(irq_n)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_STATUS: bus_rdata = vis;
      OFS_MASK:   bus_rdata = mask_q;
      default:    bus_rdata = '0;
    endcase
  end

  AST_FRAME_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (vis[BYP_BIT-1:0] == '0) |-> irq_n) else $error("frame bit drove pin"); // R4
  AST_OVF_NEEDS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!vis[BIT_OVF] && !mask_q[BIT_OVF] && !win_close) |=> !vis[BIT_OVF]) else $error("overflow w/o close"); // R7
endmodule

// File: tb/test_irq_stat_unit.sv
module test_irq_stat_unit;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0, chan_en = '0;
  logic       bus_rd = 0, bus_wr = 0, frame_evt = 0, win_open = 0, win_close = 0, xfer_access = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [4:0] ext_evt = '0;
  logic       irq_n;

  int checks = 0, errors = 0;
  bit chk_on = 0;

  logic [7:0] m_pend, m_mask;
  int         m_blank;
  bit         m_act, m_tch;

  always #2.5 clk = ~clk;

  irq_stat_unit i_irq_stat_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n), .ext_evt(ext_evt),
    .frame_evt(frame_evt), .chan_en(chan_en), .win_open(win_open), .win_close(win_close),
    .xfer_access(xfer_access)
  );

  function automatic logic [7:0] m_vis();
    return (m_pend & ~m_mask) | (m_pend & 8'h80);
  endfunction

  function automatic logic m_irq_n();
    return !(|(m_vis() & 8'h7F)) || (m_blank > 0);
  endfunction

  function automatic logic [7:0] m_rdata();
    case (bus_addr)
      2'd0: return m_vis();
      2'd1: return m_mask;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_mask = '0; m_blank = 0; m_act = 0; m_tch = 0;
  endtask

  task automatic model_edge();
    logic [7:0] v, clr, evt;
    logic req, ovf, wop;
    v   = m_vis();
    req = |(v & 8'h7F);
    ovf = win_close && m_act && !(m_tch || xfer_access);
    wop = win_open && (chan_en != 2'b00);
    evt = {frame_evt, ext_evt, wop, ovf};
    clr = (bus_rd && bus_addr == 2'd0) ? v : 8'h00;
    m_pend = (m_pend & ~clr) | evt;
    if (bus_wr && bus_addr == 2'd1 && req) m_blank = 2;
    else if (m_blank > 0) m_blank--;
    if (bus_wr && bus_addr == 2'd1) m_mask = bus_wdata;
    if (wop) begin m_act = 1; m_tch = 0; end
    else if (win_close) m_act = 0;
    else if (m_act && xfer_access) m_tch = 1;
  endtask

  // auto checks, clock edge, model update, return idle inputs settled
  task automatic tick();
    if (chk_on) begin
      chk("R2 irq_n", {7'd0, irq_n}, {7'd0, m_irq_n()});
      if (bus_rd) chk("R8 rdata", bus_rdata, m_rdata());
    end
    @(posedge clk);
    if (!rst_n) model_reset(); else model_edge();
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; ext_evt = '0; frame_evt = 0;
    win_open = 0; win_close = 0; xfer_access = 0;
    #1;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [7:0] exp);
    bus_addr = a; bus_rd = 1; #1;
    chk(tag, bus_rdata, exp);
    tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d; tick();
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    model_reset();
    @(negedge clk); #1;
    repeat (4) tick();
    rst_n = 1; #1;
    chk_on = 1;
    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
    rd(2'd1, "R1 mask", 8'h00);
    rd(2'd0, "R1 status", 8'h00);
    // R3 masked event held, appears on unmask
    wr(2'd1, 8'h04);
    ext_evt = 5'b00001; tick();
    chk("R3 hidden irq_n", {7'd0, irq_n}, 8'd1);
    rd(2'd0, "R3 hidden status", 8'h00);
    wr(2'd1, 8'h00);
    chk("R3 irq_n after unmask", {7'd0, irq_n}, 8'd0);
    rd(2'd0, "R3 status after unmask", 8'h04);
    chk("R8 irq_n after read", {7'd0, irq_n}, 8'd1);
    rd(2'd0, "R8 cleared", 8'h00);
    // R4 frame bit bypasses mask, never drives pin
    wr(2'd1, 8'h80);
    frame_evt = 1; tick();
    chk("R4 irq_n", {7'd0, irq_n}, 8'd1);
    rd(2'd0, "R4 status", 8'h80);
    // R5 blanking pulse
    ext_evt = 5'b00010; tick();
    chk("R5 asserted", {7'd0, irq_n}, 8'd0);
    wr(2'd1, 8'h80);
    chk("R5 blank 1", {7'd0, irq_n}, 8'd1);
    tick();
    chk("R5 blank 2", {7'd0, irq_n}, 8'd1);
    tick();
    chk("R5 re-evaluated", {7'd0, irq_n}, 8'd0);
    rd(2'd0, "R5 status", 8'h08);
    // R6 window-open gated by channel enables
    chan_en = 2'b00; win_open = 1; tick();
    rd(2'd0, "R6 disabled", 8'h00);
    win_close = 1; tick();
    rd(2'd0, "R7 no window no overflow", 8'h00);
    chan_en = 2'b01; win_open = 1; tick();
    rd(2'd0, "R6 enabled", 8'h02);
    // R7 overflow on untouched close
    win_close = 1; tick();
    rd(2'd0, "R7 overflow", 8'h01);
    chan_en = 2'b10; win_open = 1; tick();
    xfer_access = 1; tick();
    win_close = 1; tick();
    rd(2'd0, "R7 accessed", 8'h02);
    win_open = 1; tick();
    win_close = 1; xfer_access = 1; tick();
    rd(2'd0, "R7 access at close", 8'h02);
    // R9 event in same cycle as clearing read
    ext_evt = 5'b00100; tick();
    ext_evt = 5'b00100; rd(2'd0, "R9 shown", 8'h10);
    rd(2'd0, "R9 survives", 8'h10);
    // R10 map
    wr(2'd0, 8'hFF);
    rd(2'd0, "R10 status write ignored", 8'h00);
    wr(2'd1, 8'h5A);
    rd(2'd1, "R10 mask rw", 8'h5A);
    rd(2'd2, "R10 offset2", 8'h00);
    rd(2'd3, "R10 offset3", 8'h00);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      bus_addr = 2'($urandom_range(0, 3));
      if (r < 20) bus_rd = 1;
      else if (r < 28) begin bus_wr = 1; bus_wdata = 8'($urandom); if ($urandom_range(0,1)) bus_addr = 2'd1; end
      if ($urandom_range(0, 9) == 0) ext_evt = 5'($urandom);
      frame_evt   = ($urandom_range(0, 19) == 0);
      win_open    = ($urandom_range(0, 14) == 0);
      win_close   = ($urandom_range(0, 9) == 0);
      xfer_access = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 29) == 0) chan_en = 2'($urandom);
      #1;
      tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule